// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital core of a stepped resistive wiper with 32 positions. Two slow control lines, an active-low select and an up/down line, arrive without any clock relationship. The block samples them with a free-running system clock. At the start of each session, when select falls, it reads the up/down level to choose a direction. While the session lasts, every rising edge on the up/down line moves the wiper by one position in that direction.

The position is held in a saturating counter that resets to midscale. It is driven out in two forms: a binary tap index and a registered one-hot select word for the switch array. Two flags report when the wiper sits at either end of its range. A sticky flag records a step edge that came too soon after the session started. That flag is how setup violations from the external controller become visible.

Control and status pins are plain levels. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `wiper_stepper`

## Requirements
- R1: After reset the tap index is 16, the one-hot select has only bit 16 set, the timing error flag is 0, and the direction is increment.
- R2: When select goes from high to low, the direction is latched: increment if up/down is high (1), decrement if up/down is low (0).
- R3: The latched direction does not change until the next select falling edge, whatever the up/down level does during the session.
- R4: While select is low, each rising edge on up/down moves the tap index by exactly one position. The new value appears on the third rising clock edge after the input rise.
- R5: An increment at index 31 leaves the index at 31, and a decrement at index 0 leaves it at 0. The index never wraps.
- R6: While select is high, rising edges on up/down have no effect, and the tap index holds its last value.
- R7: In every clock cycle the one-hot select has exactly one bit set, and that bit is at the position given by the tap index.
- R8: at_min is 1 exactly when the index is 0, and at_max is 1 exactly when the index is 31.
- R9: If an up/down rising edge is detected in the same clock cycle as the select falling edge, it only sets the direction and does not step the wiper.
- R10: timing_err is set when an up/down rising edge is detected during a session fewer than MIN_GAP clocks (default 4) after the select falling edge. Once set, it stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_in | input | 1 | Asynchronous active-low session select |
| updn_in | input | 1 | Asynchronous direction level at session start, step clock during a session |
| tap_idx | output | 5 | Current wiper position, 0 to 31 |
| tap_onehot | output | 32 | One-hot tap select for the switch array |
| at_min | output | 1 | Wiper is at position 0 |
| at_max | output | 1 | Wiper is at position 31 |
| timing_err | output | 1 | Sticky flag for a step that came too early in a session |

## Verification
Each input passes through two synchroniser flops and then an edge-detect stage, and only after that reaches the state registers. A change on a pin therefore shows up on tap_idx, tap_onehot and timing_err on the third rising clock edge after it. The latched direction also takes effect three edges after select falls.

The bench drives inputs on falling clock edges and holds every level for four clock cycles. It samples all outputs on the falling edge after that hold, one cycle after the result is due. For the early-step case, the up/down rise is placed exactly one clock after the select fall. The coincident case drives both lines on the same falling edge, so both edges are detected in the same cycle.

// File: rtl/wiper_pkg.sv
`timescale 1ns/1ps
package wiper_pkg;
  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } dir_e;
endpackage

// File: rtl/wiper_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser followed by a single edge-detect register.
module wiper_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d_async;
    end
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/wiper_session.sv
`timescale 1ns/1ps
// Session control: direction latch, step qualification, early-step monitor.
module wiper_session
  import wiper_pkg::*;
#(
  parameter int MIN_GAP = 4,
  localparam int GAP_W  = $clog2(MIN_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_lvl,   // synchronised, 1 = idle
  input  logic sel_fall,
  input  logic ud_lvl,
  input  logic ud_rise,
  output dir_e dir,
  output logic step,
  output logic late_err
);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] gap;
  logic             active;
  logic             early;

  assign active = ~sel_lvl;
  assign step   = ud_rise & active & ~sel_fall;
  assign early  = ud_rise & active & (sel_fall | (gap < GAP_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= DIR_UP;
    end else if (sel_fall) begin
      dir <= dir_e'(ud_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (sel_fall) begin
      gap <= GAP_W'(1);
    end else if (active && (gap < GAP_LIM)) begin
      gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     late_err <= 1'b0;
    else if (early) late_err <= 1'b1;
  end
endmodule

// File: rtl/wiper_counter.sv
`timescale 1ns/1ps
// Saturating tap counter with a registered one-hot decode.
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int TAPS = 32,
  localparam int W   = $clog2(TAPS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  dir_e           dir,
  output logic [W-1:0]   idx,
  output logic [TAPS-1:0] onehot
);
  localparam logic [W-1:0] TOP = W'(TAPS - 1);
  localparam logic [W-1:0] MID = W'(TAPS / 2);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = idx;
    if (step) begin
      if (dir == DIR_UP) begin
        if (idx != TOP) nxt = idx + 1'b1;
      end else begin
        if (idx != '0) nxt = idx - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= MID;
    else        idx <= nxt;
  end

  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) onehot[t] <= (t == TAPS / 2);
        else        onehot[t] <= (nxt == W'(t));
      end
    end
  endgenerate
endmodule

// File: rtl/wiper_stepper.sv
`timescale 1ns/1ps
module wiper_stepper
  import wiper_pkg::*;
#(
  parameter int  TAPS        = 32,
  parameter int  SYNC_STAGES = 2,
  parameter int  MIN_GAP     = 4,
  localparam int IDX_W       = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_in,
  input  logic             updn_in,
  output logic [IDX_W-1:0] tap_idx,
  output logic [TAPS-1:0]  tap_onehot,
  output logic             at_min,
  output logic             at_max,
  output logic             timing_err
);
  logic sel_lvl, sel_rise_unused, sel_fall;
  logic ud_lvl, ud_rise, ud_fall_unused;
  logic step;
  dir_e dir;

  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sel_n_in),
    .lvl(sel_lvl), .rise(sel_rise_unused), .fall(sel_fall)
  );

  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ud_sync (
    .clk(clk), .rst_n(rst_n), .d_async(updn_in),
    .lvl(ud_lvl), .rise(ud_rise), .fall(ud_fall_unused)
  );

  wiper_session #(.MIN_GAP(MIN_GAP)) u_session (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(sel_lvl), .sel_fall(sel_fall),
    .ud_lvl(ud_lvl), .ud_rise(ud_rise),
    .dir(dir), .step(step), .late_err(timing_err)
  );

  wiper_counter #(.TAPS(TAPS)) u_counter (
    .clk(clk), .rst_n(rst_n), .step(step), .dir(dir),
    .idx(tap_idx), .onehot(tap_onehot)
  );

  assign at_min = (tap_idx == '0);
  assign at_max = (tap_idx == IDX_W'(TAPS - 1));

  logic unused_ok;
  assign unused_ok = sel_rise_unused ^ ud_fall_unused;
endmodule

// File: rtl/wiper_stepper_chk.sv
`timescale 1ns/1ps
module wiper_stepper_chk #(
  parameter int  TAPS  = 32,
  localparam int IDX_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n_in,
  input logic [IDX_W-1:0] tap_idx,
  input logic [TAPS-1:0]  tap_onehot,
  input logic             timing_err
);
  logic [3:0] idle_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_hist <= '0;
    else        idle_hist <= {idle_hist[2:0], sel_n_in};
  end

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_onehot) == 1); // R7
  AST_TAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tap_onehot[tap_idx] == 1'b1); // R7
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tap_idx == $past(tap_idx)) || (32'(tap_idx) == 32'($past(tap_idx)) + 1)
             || (32'(tap_idx) + 1 == 32'($past(tap_idx)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hist == 4'b1111) |=> $stable(tap_idx)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err); // R10
endmodule

bind wiper_stepper wiper_stepper_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n_in),
  .tap_idx(tap_idx), .tap_onehot(tap_onehot), .timing_err(timing_err)
);

// File: tb/wiper_stepper_test.sv
`timescale 1ns/1ps
module wiper_stepper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n_in = 1'b1;
  logic        updn_in = 1'b0;
  logic [4:0]  tap_idx;
  logic [31:0] tap_onehot;
  logic        at_min, at_max, timing_err;

  int compared = 0;
  int mismatched = 0;
  int exp_tap = 16;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_stepper uut (
    .clk(clk), .rst_n(rst_n), .sel_n_in(sel_n_in), .updn_in(updn_in),
    .tap_idx(tap_idx), .tap_onehot(tap_onehot),
    .at_min(at_min), .at_max(at_max), .timing_err(timing_err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pos(input string req);
    chk(req, tap_idx, exp_tap);
    chk("R7", tap_onehot, 64'(32'd1 << exp_tap));
    chk("R8 min", at_min, exp_tap == 0);
    chk("R8 max", at_max, exp_tap == 31);
  endtask

  task automatic pulse;
    updn_in = 1'b1; wait_cyc(4);
    updn_in = 1'b0; wait_cyc(4);
  endtask

  task automatic open_session(input bit up);
    updn_in = up; wait_cyc(4);
    sel_n_in = 1'b0; wait_cyc(4);
    updn_in = 1'b0; wait_cyc(4);   // R3: level changes mid-session
  endtask

  task automatic close_session;
    sel_n_in = 1'b1; wait_cyc(4);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    exp_tap = 16;
    check_pos("R1");
    chk("R1 err", timing_err, 0);

    // R6 steps without a session are ignored
    for (int i = 0; i < 5; i++) begin
      pulse();
      check_pos("R6");
    end

    // R2/R3/R4/R5 increment sweep into saturation
    open_session(1'b1);
    for (int i = 0; i < 20; i++) begin
      pulse();
      exp_tap = (exp_tap < 31) ? exp_tap + 1 : 31;
      check_pos("R5 up");
    end
    close_session();
    for (int i = 0; i < 3; i++) begin
      pulse();
      check_pos("R6 hold");
    end

    // decrement sweep through the whole range into saturation at 0
    open_session(1'b0);
    for (int i = 0; i < 40; i++) begin
      pulse();
      exp_tap = (exp_tap > 0) ? exp_tap - 1 : 0;
      check_pos("R5 dn");
    end
    close_session();

    // R4 three-edge latency: changes on third edge, not before
    open_session(1'b1);
    updn_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R4 early", tap_idx, exp_tap);
    @(posedge clk); #1;
    exp_tap = exp_tap + 1;
    chk("R4 due", tap_idx, exp_tap);
    wait_cyc(3); updn_in = 1'b0; wait_cyc(4);
    pulse(); pulse();
    exp_tap = exp_tap + 2;
    check_pos("R2 up");
    chk("R10 clean", timing_err, 0);
    close_session();

    // R10 step one clock after the select fall
    updn_in = 1'b0; wait_cyc(4);
    sel_n_in = 1'b0; wait_cyc(1);
    updn_in = 1'b1; wait_cyc(4);
    exp_tap = exp_tap - 1;
    check_pos("R10 step");
    chk("R10 set", timing_err, 1);
    updn_in = 1'b0; wait_cyc(4);
    close_session();

    // R9 coincident edges: mode only, no step
    updn_in = 1'b0; wait_cyc(4);
    sel_n_in = 1'b0; updn_in = 1'b1; wait_cyc(5);
    check_pos("R9 nostep");
    updn_in = 1'b0; wait_cyc(4);
    pulse(); pulse();
    exp_tap = exp_tap + 2;
    check_pos("R9 dir up");
    chk("R10 sticky", timing_err, 1);
    close_session();

    // R1 reset again mid-operation
    rst_n = 1'b0; wait_cyc(2);
    rst_n = 1'b1; wait_cyc(2);
    exp_tap = 16;
    check_pos("R1 again");
    chk("R1 err clr", timing_err, 0);

    done = 1;
    report();
  end
endmodule